// File: doc/BRIEF.md
# Burst Read Master with Credit-Throttled Return Buffer

This block pulls one frame's worth of words out of external memory for a pixel unpacker further down the stream. It is given a starting byte address and a word count. It then splits the fetch into burst read commands no longer than a build-time target length, places each command on a memory-mapped master port that observes waitrequest, and writes the words that come back under readdatavalid into a synchronous first-word-fall-through buffer. The unpacker drains that buffer through a valid/ready pair.

A burst is placed on the bus only when the buffer can hold every word of it. The space counted against a new burst includes the words of earlier bursts that have not yet returned. Because of this, readdatavalid is never refused and never lost. The last burst of a frame is cut down to the number of words still owed. When the received count reaches the programmed count, the block raises a one-cycle completion pulse and becomes free to take the next frame.

Control is a four-state machine. ST_IDLE waits for `start` and moves to ST_CHECK, capturing the address and the count. ST_CHECK moves to ST_WAIT once nothing is left to request. It moves to ST_REQ when the free credit covers the next burst, and otherwise it stays where it is. ST_REQ drives the command and returns to ST_CHECK on the cycle waitrequest is low. ST_WAIT returns to ST_IDLE in the cycle the received count equals the programmed count, and that is the cycle `frame_done` is high.

Top module: `burst_fetch_top`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `mem_read`, `out_valid`, `busy` and `frame_done` are all 0.
- R2: The first burst of a frame carries `base_addr` as its address. Each later burst's address is the previous one plus its burstcount × DATA_W/8.
- R3: Every burstcount equals the lesser of BURST_MAX and the words not yet requested. The burstcounts of one frame add up to `word_count`.
- R4: When a burst is accepted, FIFO_DEPTH minus the buffered words minus the requested-but-unreturned words is at least its burstcount. The buffer therefore never overflows.
- R5: While `mem_read` is high and `mem_waitrequest` is high, `mem_read`, `mem_addr` and `mem_burstcount` keep their values in the following cycle.
- R6: Returned words appear on `out_data` in arrival order, with `out_valid` high whenever the buffer holds a word. While `out_ready` is low, `out_valid` and `out_data` do not change.
- R7: `busy` is high from the cycle after an accepted `start` through the cycle of `frame_done`. `frame_done` is a single-cycle pulse that occurs once per frame, and only after every programmed word has been received.
- R8: A `start` pulse seen while `busy` is high is ignored. The frame in progress keeps its address sequence and count.
- R9: A frame with `word_count` of 0 issues no read and still produces its `frame_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame fetch (taken only when idle) |
| base_addr | input | ADDR_W | Byte address of the first word of the frame |
| word_count | input | CNT_W | Number of words to fetch |
| busy | output | 1 | A frame fetch is in progress |
| frame_done | output | 1 | One-cycle pulse when all words have been received |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_burstcount | output | LEN_W | Words in the current burst |
| mem_read | output | 1 | Burst read command valid |
| mem_waitrequest | input | 1 | Memory stalls the command |
| mem_readdata | input | DATA_W | Returned word |
| mem_readdatavalid | input | 1 | Returned word valid |
| out_data | output | DATA_W | Buffered word to the unpacker |
| out_valid | output | 1 | Buffered word available |
| out_ready | input | 1 | Unpacker takes the word |

## Verification
The assertions check the following on every clock: the command is held while the memory stalls it, the burst length stays within bounds, the credit covers each burst at the moment it is accepted, the buffer never overflows or underflows, the output is held under backpressure, and the completion pulse lasts one cycle. What no local property can show is the arithmetic of a whole frame: the address sequence, the shortened final burst, data order end to end, the exact `busy` window, the ignored mid-frame `start` and the zero-length frame. The bench's behavioural model covers these, with random stalls, slow returns and heavy backpressure.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

    // Fetch controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_REQ   = 2'd2,
        ST_WAIT  = 2'd3
    } fetch_state_t;

endpackage

// File: rtl/bfr_sync_fifo.sv
module bfr_sync_fifo #(
    parameter int DATA_W = 256,
    parameter int DEPTH  = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic [LVL_W-1:0]  level
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (rd_en) rd_ptr <= ptr_next(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign rd_data = store[rd_ptr];
    assign empty   = (level == '0);

    // R4: the credit scheme must never let a returned word find the buffer full
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |-> (int'(level) < DEPTH));

    // R6: a word is only taken when one is present
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

endmodule

// File: rtl/bfr_rx_tracker.sv
module bfr_rx_tracker #(
    parameter int CNT_W = 23,
    parameter int LEN_W = 6,
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             issue_fire,
    input  logic [LEN_W-1:0] issue_len,
    input  logic             word_valid,
    output logic [CNT_W-1:0] rx_count,
    output logic [LVL_W-1:0] outstanding
);

    logic [LVL_W-1:0] add_amt;
    logic [LVL_W-1:0] sub_amt;

    always_comb begin
        add_amt = issue_fire ? LVL_W'(issue_len) : '0;
        sub_amt = word_valid ? LVL_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_count    <= '0;
            outstanding <= '0;
        end else begin
            outstanding <= outstanding + add_amt - sub_amt;
            if (clear)           rx_count <= '0;
            else if (word_valid) rx_count <= rx_count + 1'b1;
        end
    end

    // R4: memory may only return words that were requested
    assert_rx_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (outstanding != '0));

endmodule

// File: rtl/bfr_issue_fsm.sv
module bfr_issue_fsm
    import bfr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 23,
    parameter int LEN_W      = 6,
    parameter int LVL_W      = 7,
    parameter int BURST_MAX  = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int BYTES      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              waitrequest,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  outstanding,
    input  logic [CNT_W-1:0]  rx_count,
    output logic              mem_read,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_burstcount,
    output logic              burst_fire,
    output logic              busy,
    output logic              frame_done,
    output logic              clear
);

    fetch_state_t     state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  total_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  len_calc;
    logic              room_ok;
    logic              all_rx;

    always_comb begin
        len_calc = (remain_q >= CNT_W'(BURST_MAX)) ? LEN_W'(BURST_MAX) : LEN_W'(remain_q);
        room_ok  = (FIFO_DEPTH - int'(fifo_level) - int'(outstanding)) >= int'(len_calc);
        all_rx   = (rx_count == total_q);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (remain_q == '0) state_d = ST_WAIT;
                else if (room_ok)   state_d = ST_REQ;
            end
            ST_REQ:   if (!waitrequest) state_d = ST_CHECK;
            ST_WAIT:  if (all_rx) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_read   = (state_q == ST_REQ);
        burst_fire = (state_q == ST_REQ) && !waitrequest;
        busy       = (state_q != ST_IDLE);
        frame_done = (state_q == ST_WAIT) && all_rx;
        clear      = (state_q == ST_IDLE) && start;
    end

    // command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            total_q  <= '0;
            len_q    <= '0;
        end else begin
            if (clear) begin
                addr_q   <= base_addr;
                remain_q <= word_count;
                total_q  <= word_count;
            end else if (burst_fire) begin
                addr_q   <= addr_q + ADDR_W'(len_q) * ADDR_W'(BYTES);
                remain_q <= remain_q - CNT_W'(len_q);
            end
            if (state_q == ST_CHECK && state_d == ST_REQ) len_q <= len_calc;
        end
    end

    assign mem_addr       = addr_q;
    assign mem_burstcount = len_q;

    // R5: a stalled command is held unchanged
    assert_hold_under_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && waitrequest) |=> (mem_read && $stable(mem_addr) && $stable(mem_burstcount)));

    // R3: burst length bounded by the target
    assert_burst_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read |-> (mem_burstcount != '0 && int'(mem_burstcount) <= BURST_MAX));

    // R4: buffer space minus words in flight covers the accepted burst
    assert_credit_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_fire |-> ((FIFO_DEPTH - int'(fifo_level) - int'(outstanding)) >= int'(mem_burstcount)));

    // R7: completion is a single-cycle pulse
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7: never more words received than programmed
    assert_rx_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear) |-> (rx_count <= total_q));

endmodule

// File: rtl/burst_fetch_top.sv
module burst_fetch_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 256,
    parameter int FIFO_DEPTH = 64,
    parameter int BURST_MAX  = 32,
    parameter int CNT_W      = 23,
    localparam int LEN_W     = $clog2(BURST_MAX + 1),
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int BYTES     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_count,
    output logic              busy,
    output logic              frame_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_burstcount,
    output logic              mem_read,
    input  logic              mem_waitrequest,
    input  logic [DATA_W-1:0] mem_readdata,
    input  logic              mem_readdatavalid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    logic             fifo_empty;
    logic [LVL_W-1:0] fifo_level;
    logic [LVL_W-1:0] outstanding;
    logic [CNT_W-1:0] rx_count;
    logic             burst_fire;
    logic             clear;
    logic             pop;

    assign out_valid = !fifo_empty;
    assign pop       = out_ready && !fifo_empty;

    bfr_issue_fsm #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .LVL_W(LVL_W),
        .BURST_MAX(BURST_MAX), .FIFO_DEPTH(FIFO_DEPTH), .BYTES(BYTES)
    ) issue_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_count(word_count), .waitrequest(mem_waitrequest),
        .fifo_level(fifo_level), .outstanding(outstanding), .rx_count(rx_count),
        .mem_read(mem_read), .mem_addr(mem_addr), .mem_burstcount(mem_burstcount),
        .burst_fire(burst_fire), .busy(busy), .frame_done(frame_done), .clear(clear)
    );

    bfr_rx_tracker #(
        .CNT_W(CNT_W), .LEN_W(LEN_W), .LVL_W(LVL_W)
    ) track_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .issue_fire(burst_fire),
        .issue_len(mem_burstcount), .word_valid(mem_readdatavalid),
        .rx_count(rx_count), .outstanding(outstanding)
    );

    bfr_sync_fifo #(
        .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)
    ) fifo_i (
        .clk(clk), .rst_n(rst_n), .wr_en(mem_readdatavalid), .wr_data(mem_readdata),
        .rd_en(pop), .rd_data(out_data), .empty(fifo_empty), .level(fifo_level)
    );

    // R6: the offered word is held while the unpacker stalls
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/burst_fetch_top_tb_top.sv
module burst_fetch_top_tb_top;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int DEPTH = 16;
    localparam int BMAX  = 8;
    localparam int CW    = 16;
    localparam int LW    = $clog2(BMAX + 1);
    localparam int BPW   = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic          busy, frame_done;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_burstcount;
    logic          mem_read;
    logic          mem_waitrequest = 1'b0;
    logic [DW-1:0] mem_readdata = '0;
    logic          mem_readdatavalid = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          out_ready = 1'b0;

    always #4 clk = ~clk;

    burst_fetch_top #(
        .ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(DEPTH), .BURST_MAX(BMAX), .CNT_W(CW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_count(word_count), .busy(busy), .frame_done(frame_done),
        .mem_addr(mem_addr), .mem_burstcount(mem_burstcount), .mem_read(mem_read),
        .mem_waitrequest(mem_waitrequest), .mem_readdata(mem_readdata),
        .mem_readdatavalid(mem_readdatavalid), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference model
    bit          m_active = 0;
    logic [AW-1:0] m_addr = '0;
    int          m_remain = 0;
    int          m_total = 0;
    int          m_rx = 0;
    int          done_cnt = 0;
    logic [DW-1:0] mq[$];
    int          pend[$];
    bit          prev_wait = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [LW-1:0] prev_bc = '0;

    // stimulus knobs
    int          wait_pct = 0;
    int          ready_pct = 100;
    int          rv_pct = 100;
    bit          start_req = 0;
    logic [AW-1:0] req_base = '0;
    int          req_cnt = 0;

    function automatic logic [DW-1:0] pat(input int w);
        return DW'(w) * 32'h0000_9E37 + 32'h0000_0051;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        int exp_len;
        @(negedge clk);
        // compare DUT against model state after previous edges
        chk(busy === m_active, "R7", "busy", 64'(busy), 64'(m_active));
        chk(out_valid === (mq.size() != 0), "R6", "out_valid", 64'(out_valid), 64'(mq.size() != 0));
        if (mq.size() != 0)
            chk(out_data === mq[0], "R6", "out_data", 64'(out_data), 64'(mq[0]));
        chk(mq.size() + pend.size() <= DEPTH, "R4", "buffered+inflight",
            64'(mq.size() + pend.size()), 64'(DEPTH));
        if (prev_wait)
            chk(mem_read && mem_addr === prev_addr && mem_burstcount === prev_bc, "R5",
                "held command addr", 64'(mem_addr), 64'(prev_addr));
        if (frame_done === 1'b1) begin
            chk(m_active && m_remain == 0 && m_rx == m_total, "R7", "done rx count",
                64'(m_rx), 64'(m_total));
            m_active = 0;
            done_cnt++;
        end
        // drive inputs for the coming edge
        start = 1'b0;
        if (start_req) begin
            start      = 1'b1;
            base_addr  = req_base;
            word_count = CW'(req_cnt);
            if (!busy) begin
                m_active = 1; m_addr = req_base; m_remain = req_cnt;
                m_total = req_cnt; m_rx = 0;
            end
            start_req = 0;
        end
        mem_waitrequest   = (($urandom % 100) < wait_pct);
        out_ready         = (($urandom % 100) < ready_pct);
        mem_readdatavalid = (pend.size() > 0) && (($urandom % 100) < rv_pct);
        mem_readdata      = mem_readdatavalid ? pat(pend[0]) : '0;
        // transfers that the coming edge performs
        if (mem_read && !mem_waitrequest) begin
            exp_len = (m_remain < BMAX) ? m_remain : BMAX;
            chk(m_active && m_remain > 0, "R9", "read with nothing owed", 64'(mem_burstcount), 64'(0));
            chk(mem_addr === m_addr, "R2", "burst address", 64'(mem_addr), 64'(m_addr));
            chk(int'(mem_burstcount) == exp_len, "R3", "burstcount", 64'(mem_burstcount), 64'(exp_len));
            chk(DEPTH - mq.size() - pend.size() >= int'(mem_burstcount), "R4", "credit at accept",
                64'(DEPTH - mq.size() - pend.size()), 64'(mem_burstcount));
            for (int i = 0; i < int'(mem_burstcount); i++) pend.push_back(int'(mem_addr / BPW) + i);
            m_addr   = m_addr + AW'(mem_burstcount) * AW'(BPW);
            m_remain = m_remain - int'(mem_burstcount);
        end
        if (mem_readdatavalid) begin
            mq.push_back(pat(pend[0]));
            void'(pend.pop_front());
            m_rx++;
        end
        if (out_valid && out_ready) void'(mq.pop_front());
        prev_wait = mem_read && mem_waitrequest;
        prev_addr = mem_addr;
        prev_bc   = mem_burstcount;
    endtask

    task automatic launch(input logic [AW-1:0] b, input int c);
        int guard = 0;
        while (busy && guard < 5000) begin tick(); guard++; end
        req_base = b; req_cnt = c; start_req = 1;
        tick();
    endtask

    task automatic finish_frame(input string req);
        int guard = 0;
        int d0 = done_cnt;
        while (m_active && guard < 20000) begin tick(); guard++; end
        chk(!m_active, req, "frame completed", 64'(m_active), 64'(0));
        ready_pct = 100;
        guard = 0;
        while ((mq.size() != 0 || busy) && guard < 2000) begin tick(); guard++; end
        chk(done_cnt == d0 + 1, req, "one done pulse", 64'(done_cnt - d0), 64'(1));
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired R7 actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_read === 1'b0 && out_valid === 1'b0 && busy === 1'b0 && frame_done === 1'b0,
            "R1", "outputs in reset", 64'({mem_read, out_valid, busy, frame_done}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_read === 1'b0 && out_valid === 1'b0 && busy === 1'b0 && frame_done === 1'b0,
            "R1", "outputs after reset", 64'({mem_read, out_valid, busy, frame_done}), 64'(0));

        // R2/R3: 20 words, final burst shortened to 4, no stalls
        wait_pct = 0; ready_pct = 100; rv_pct = 100;
        launch(32'h0000_1000, 20);
        finish_frame("R3");

        // R5/R6: short frame under stalls and backpressure
        wait_pct = 50; ready_pct = 50; rv_pct = 60;
        launch(32'h0000_2000, 3);
        finish_frame("R5");

        // R3: count exactly one burst target
        wait_pct = 30; ready_pct = 70; rv_pct = 80;
        launch(32'h0000_3000, BMAX);
        finish_frame("R3");

        // R9: zero-length frame
        wait_pct = 0; ready_pct = 100; rv_pct = 100;
        launch(32'h0000_4000, 0);
        finish_frame("R9");

        // R4: heavy backpressure forces credit throttling
        wait_pct = 20; ready_pct = 5; rv_pct = 100;
        launch(32'h0001_0000, 60);
        finish_frame("R4");

        // R8: start pulsed in the middle of a frame
        wait_pct = 25; ready_pct = 40; rv_pct = 70;
        launch(32'h0000_5000, 30);
        repeat (6) tick();
        chk(busy === 1'b1, "R8", "busy before stray start", 64'(busy), 64'(1));
        req_base = 32'h0000_9000; req_cnt = 5; start_req = 1;
        tick();
        finish_frame("R8");
        chk(m_total == 30 && m_rx == 30, "R8", "words of original frame", 64'(m_rx), 64'(30));

        // R7: idle afterwards, no further pulses
        seen = done_cnt;
        repeat (10) tick();
        chk(done_cnt == seen && busy === 1'b0, "R7", "quiet when idle", 64'(done_cnt - seen), 64'(0));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule